// File: doc/BRIEF.md
# Eight-Operand Carry-Save Reduction Tree with Absorbed Carry-Ins

This block takes eight unsigned partial products and one carry-in bit per partial product. It reduces them to a redundant pair, a sum vector and a carry vector, using only rows of full adders. A Booth-style multiplier bank produces a partial product plus an increment bit for each coefficient. The tree folds six of those increment bits into the empty lowest bit of the carry vectors it builds. The last two increment bits leave the block untouched, and a later carry-save or carry-propagate stage consumes them. No half adders appear anywhere, and there is no separate tree for the carry-ins.

The reduction runs through four carry-save levels that cut the operand count from 8 to 6, then 4, then 3, then 2. Each level shifts the carry-in list down by the number of full-adder rows it used. A parameter sets a pipeline register after every level, after every second level, or nowhere. All outputs pass through the same registers, so they leave the block aligned. Vectors are `PW+3` bits wide, which is enough for the sum of eight `PW`-bit operands. Any arithmetic beyond that width wraps.

Top module: `cst_tree`

## Requirements
- R1: With `OW = PW+3`, the value `sum_o + carry_o + spare_o[0] + spare_o[1]` equals, modulo 2^OW, the sum of the eight zero-extended partial products (operand j in `pp_i[j*PW +: PW]`) plus the number of set bits in `cin_i`.
- R2: Latency from inputs to outputs is 4 cycles when `PIPE=1` (register after every level), 2 cycles when `PIPE=2` (register after levels two and four), and 0 when `PIPE=0`.
- R3: While the synchronised reset is active, and in the cycles after its release before the first post-reset input reaches the outputs, `sum_o`, `carry_o` and `spare_o` are all zero.
- R4: `spare_o[0]` carries `cin_i[6]` and `spare_o[1]` carries `cin_i[7]`, each delayed by the latency of R2.
- R5: Bit 0 of `carry_o` equals `cin_i[5]`, delayed by the latency of R2. That carry-in is the one absorbed by the last full-adder row.
- R6: When every carry-in is zero and only partial product 0 (`pp_i[PW-1:0]`) is nonzero, `sum_o` equals that operand and `carry_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pp_i | input | 8*PW | Eight packed partial products, operand j at bits j*PW and up |
| cin_i | input | 8 | Carry-in bit for each partial product |
| sum_o | output | PW+3 | Sum vector of the redundant result |
| carry_o | output | PW+3 | Carry vector of the redundant result |
| spare_o | output | 2 | The two carry-ins left unabsorbed (bit 0 from cin 6, bit 1 from cin 7) |

## Verification
The bench builds two copies at `PW=5`, giving 8-bit output vectors. One copy has `PIPE=1` and the other `PIPE=2`. Both see the same stimulus, so the four-cycle and two-cycle alignments of R2 are each compared against one reference history. The narrow width makes the modulo wrap of R1 reachable on purpose: all-ones operands with every carry-in set sum to exactly 2^8. The stimulus also includes the isolated-operand pattern of R6, carry-in-only patterns, and random mixes.

// File: rtl/cst_pkg.sv
package cst_pkg;

  // Tree shape is fixed at eight operands reduced over four carry-save levels
  localparam int NUM_PP  = 8;
  localparam int NUM_LVL = 4;

  // Full-adder rows used at a level: 8->6 and 6->4 need two, 4->3 and 3->2 need one
  function automatic int rows_at(input int lvl);
    return (lvl <= 2) ? 2 : 1;
  endfunction

  // Whether a register follows the given level for a pipeline setting
  function automatic bit reg_after(input int lvl, input int per_stage);
    return (per_stage == 1) || ((per_stage == 2) && ((lvl % 2) == 0));
  endfunction

  function automatic int latency(input int per_stage);
    return (per_stage == 0) ? 0 : NUM_LVL / per_stage;
  endfunction

endpackage

// File: rtl/cst_rst_sync.sv
module cst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/cst_csa_row.sv
// One row of W full adders; the vacant carry LSB receives a carry-in bit
module cst_csa_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);

  logic [W-1:0] maj;

  assign s   = a ^ b ^ c;
  assign maj = (a & b) | (a & c) | (b & c);
  assign cy  = {maj[W-2:0], ci};

endmodule

// File: rtl/cst_level.sv
// One carry-save level: ROWS rows consume 3*ROWS operands and ROWS carry-ins,
// remaining operands and carry-ins shift down to fill the freed slots.
module cst_level
  import cst_pkg::*;
#(
  parameter int W    = 8,
  parameter int ROWS = 2
) (
  input  logic [NUM_PP-1:0][W-1:0] op_i,
  input  logic [NUM_PP-1:0]        ci_i,
  output logic [NUM_PP-1:0][W-1:0] op_o,
  output logic [NUM_PP-1:0]        ci_o
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    cst_csa_row #(.W(W)) u_row (
      .a  (op_i[3*r]),
      .b  (op_i[3*r+1]),
      .c  (op_i[3*r+2]),
      .ci (ci_i[r]),
      .s  (op_o[2*r]),
      .cy (op_o[2*r+1])
    );
  end

  for (genvar m = 0; 2*ROWS + m < NUM_PP; m++) begin : g_pass
    if (3*ROWS + m < NUM_PP) begin : g_fwd
      assign op_o[2*ROWS+m] = op_i[3*ROWS+m];
    end else begin : g_zero
      assign op_o[2*ROWS+m] = '0;
    end
  end

  assign ci_o = {{ROWS{1'b0}}, ci_i[NUM_PP-1:ROWS]};

endmodule

// File: rtl/cst_pipe_reg.sv
module cst_pipe_reg #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (EN) begin : g_reg
    logic [W-1:0] q_nxt;

    always_comb begin
      q_nxt = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
    end
  end else begin : g_wire
    logic byp_unused;
    assign byp_unused = clk ^ rst_n;
    assign q = d;
  end

endmodule

// File: rtl/cst_tree.sv
module cst_tree
  import cst_pkg::*;
#(
  parameter int PW   = 11,
  parameter int PIPE = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PP*PW-1:0]   pp_i,
  input  logic [NUM_PP-1:0]      cin_i,
  output logic [PW+2:0]          sum_o,
  output logic [PW+2:0]          carry_o,
  output logic [1:0]             spare_o
);

  localparam int OW = PW + 3;
  localparam int BW = NUM_PP*OW + NUM_PP;

  logic rst_sync_n;

  logic [NUM_PP-1:0][OW-1:0] op_q [0:NUM_LVL];
  logic [NUM_PP-1:0]         ci_q [0:NUM_LVL];
  logic [NUM_PP-1:0][OW-1:0] op_d [1:NUM_LVL];
  logic [NUM_PP-1:0]         ci_d [1:NUM_LVL];
  logic [BW-1:0]             bun_d [1:NUM_LVL];
  logic [BW-1:0]             bun_q [1:NUM_LVL];
  logic                      tail_unused;

  cst_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar j = 0; j < NUM_PP; j++) begin : g_in
    assign op_q[0][j] = {{(OW-PW){1'b0}}, pp_i[j*PW +: PW]};
  end
  assign ci_q[0] = cin_i;

  for (genvar k = 1; k <= NUM_LVL; k++) begin : g_lvl
    cst_level #(.W(OW), .ROWS(rows_at(k))) u_lvl (
      .op_i (op_q[k-1]),
      .ci_i (ci_q[k-1]),
      .op_o (op_d[k]),
      .ci_o (ci_d[k])
    );

    assign bun_d[k] = {op_d[k], ci_d[k]};

    cst_pipe_reg #(.W(BW), .EN(reg_after(k, PIPE))) u_reg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .d     (bun_d[k]),
      .q     (bun_q[k])
    );

    assign {op_q[k], ci_q[k]} = bun_q[k];
  end

  assign sum_o   = op_q[NUM_LVL][0];
  assign carry_o = op_q[NUM_LVL][1];
  assign spare_o = ci_q[NUM_LVL][1:0];

  assign tail_unused = ^{op_q[NUM_LVL][NUM_PP-1:2], ci_q[NUM_LVL][NUM_PP-1:2]};

endmodule

// File: rtl/cst_tree_chk.sv
module cst_tree_chk
  import cst_pkg::*;
#(
  parameter int PW   = 11,
  parameter int PIPE = 1
) (
  input logic                 clk,
  input logic                 rst_q,
  input logic [NUM_PP*PW-1:0] pp_i,
  input logic [NUM_PP-1:0]    cin_i,
  input logic [PW+2:0]        sum_o,
  input logic [PW+2:0]        carry_o,
  input logic [1:0]           spare_o
);

  localparam int OW  = PW + 3;
  localparam int LAT = latency(PIPE);

  logic [OW-1:0] in_total;
  logic [OW-1:0] out_total;
  logic [2:0]    cyc;

  always_comb begin
    in_total = '0;
    for (int j = 0; j < NUM_PP; j++) begin
      in_total = in_total + OW'(pp_i[j*PW +: PW]) + OW'(cin_i[j]);
    end
  end

  assign out_total = sum_o + carry_o + OW'(spare_o[0]) + OW'(spare_o[1]);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)            cyc <= '0;
    else if (cyc < 3'(LAT)) cyc <= cyc + 3'd1;
  end

  if (LAT == 0) begin : g_comb
    AST_TOTAL_KEPT: assert property (@(posedge clk) disable iff (!rst_q)
      out_total == in_total); // R1
    AST_SPARE_PASS: assert property (@(posedge clk) disable iff (!rst_q)
      spare_o == cin_i[7:6]); // R4
    AST_CARRY_LSB: assert property (@(posedge clk) disable iff (!rst_q)
      carry_o[0] == cin_i[5]); // R5
  end else begin : g_piped
    AST_TOTAL_KEPT: assert property (@(posedge clk) disable iff (!rst_q)
      (cyc == 3'(LAT)) |-> out_total == $past(in_total, LAT)); // R1
    AST_SPARE_PASS: assert property (@(posedge clk) disable iff (!rst_q)
      (cyc == 3'(LAT)) |-> spare_o == $past(cin_i[7:6], LAT)); // R4
    AST_CARRY_LSB: assert property (@(posedge clk) disable iff (!rst_q)
      (cyc == 3'(LAT)) |-> carry_o[0] == $past(cin_i[5], LAT)); // R5
    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
      (cyc < 3'(LAT)) |-> (sum_o == '0 && carry_o == '0 && spare_o == '0)); // R3
    AST_RESET_ZERO: assert property (@(posedge clk)
      (!rst_q) |-> (sum_o == '0 && carry_o == '0 && spare_o == '0)); // R3
  end

endmodule

bind cst_tree cst_tree_chk #(.PW(PW), .PIPE(PIPE)) u_chk (
  .clk     (clk),
  .rst_q   (rst_sync_n),
  .pp_i    (pp_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .carry_o (carry_o),
  .spare_o (spare_o)
);

// File: tb/sim_cst_tree.sv
`timescale 1ns/1ps
module sim_cst_tree;

  localparam int PW   = 5;
  localparam int OW   = PW + 3;
  localparam int NCYC = 400;
  localparam int MASK = (1 << OW) - 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [8*PW-1:0] pp;
  logic [7:0]      cin;
  logic [OW-1:0]   s0, c0, s1, c1;
  logic [1:0]      sp0, sp1;

  int  total_chk = 0;
  int  bad_chk   = 0;
  bit  done      = 1'b0;

  int  h_tot [0:NCYC-1];
  int  h_val [0:NCYC-1];
  bit  h_one [0:NCYC-1];
  bit  h_c5  [0:NCYC-1];
  bit [1:0] h_sp [0:NCYC-1];

  always #2.5 clk = ~clk;

  cst_tree #(.PW(PW), .PIPE(1)) u0 (
    .clk(clk), .rst_n(rst_n), .pp_i(pp), .cin_i(cin),
    .sum_o(s0), .carry_o(c0), .spare_o(sp0)
  );

  cst_tree #(.PW(PW), .PIPE(2)) u1 (
    .clk(clk), .rst_n(rst_n), .pp_i(pp), .cin_i(cin),
    .sum_o(s1), .carry_o(c1), .spare_o(sp1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input int n);
    int mode = n % 8;
    int t = 0;
    logic [8*PW-1:0] v = '0;
    logic [7:0] ci = '0;
    for (int j = 0; j < 8; j++) begin
      int e;
      case (mode)
        1:       e = 0;
        2:       e = (1 << PW) - 1;
        3:       e = (j == 0) ? 1 + ($urandom % ((1 << PW) - 1)) : 0;
        4:       e = 0;
        6:       e = (j == (n / 8) % 8) ? (1 << PW) - 1 : 0;
        default: e = $urandom % (1 << PW);
      endcase
      v[j*PW +: PW] = PW'(e);
      t += e;
    end
    case (mode)
      1, 3:    ci = 8'h00;
      2, 5:    ci = 8'hFF;
      default: ci = 8'($urandom);
    endcase
    for (int j = 0; j < 8; j++) t += int'(ci[j]);
    pp  = v;
    cin = ci;
    h_tot[n] = t & MASK;
    h_sp[n]  = ci[7:6];
    h_c5[n]  = ci[5];
    h_one[n] = (mode == 3);
    h_val[n] = int'(v[PW-1:0]);
  endtask

  task automatic compare(input int n, input int lat, input logic [OW-1:0] s,
                         input logic [OW-1:0] c, input logic [1:0] sp);
    if (n < lat) begin
      chk(s == '0 && c == '0 && sp == '0, "R3 flush zero", int'(s) + int'(c) + int'(sp), 0);
    end else begin
      int idx = n - lat;
      int got = (int'(s) + int'(c) + int'(sp[0]) + int'(sp[1])) & MASK;
      chk(got == h_tot[idx], "R1 R2 total after latency", got, h_tot[idx]);
      chk(sp == h_sp[idx], "R4 spare carry-ins", int'(sp), int'(h_sp[idx]));
      chk(c[0] == h_c5[idx], "R5 carry lsb", int'(c[0]), int'(h_c5[idx]));
      if (h_one[idx]) begin
        chk(s == OW'(h_val[idx]), "R6 lone operand in sum", int'(s), h_val[idx]);
        chk(c == '0, "R6 carry zero", int'(c), 0);
      end
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad_chk++;
      total_chk++;
      $display("FAIL watchdog R2 act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    pp    = '0;
    cin   = '0;
    #1 rst_n = 1'b0;
    pp  = {(8*PW){1'b1}};
    cin = 8'hFF;
    repeat (3) begin
      @(negedge clk);
      chk(s0 == '0 && c0 == '0 && sp0 == '0, "R3 reset u0", int'(s0) + int'(c0), 0);
      chk(s1 == '0 && c1 == '0 && sp1 == '0, "R3 reset u1", int'(s1) + int'(c1), 0);
    end
    pp  = '0;
    cin = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int n = 0; n < NCYC; n++) begin
      if (n > 0) @(negedge clk);
      compare(n, 4, s0, c0, sp0);
      compare(n, 2, s1, c1, sp1);
      drive(n);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

endmodule